// File: doc/BRIEF.md
# MISO Capture Point Aligner

This block sits between the SCK clock generator of an SPI master and its receive shift register. At high bus rates the data returned by a slave reaches the master late, because of pad delay and the slave's own clock-to-output time. The block moves the moment at which MISO is taken relative to the nominal sample strobe. It can capture at the strobe itself, half an SCK period later, or one full SCK period later. For each received bit it delivers one captured value with a single-cycle valid pulse.

The capture mode comes from two control bits of the transfer-control register. The `cfg_nsamp` bit lives at bit 13 of that register and `cfg_dly1` at bit 11; the register decoder drives these two pins directly. The mode and the half-period length are taken into the block only when the bus is idle. A change made during a transfer therefore applies from the next transfer onward. The half-period length is the number of module-clock cycles per SCK half period, the same count the clock generator divides by.

Delayed captures are timed by an internal countdown, not by later SCK edges. The final bit of a word can therefore still be taken after the last SCK edge. `cap_pending` tells the word-complete logic to wait until that capture has happened. The receive stream has no back-pressure. SCK keeps running regardless of the sink, so every valid pulse must be accepted in the cycle it appears.

Top module: `miso_capture_align`

## Requirements
- R1: Mode decode: `cfg_nsamp`=1 selects normal capture; `cfg_nsamp`=0 with `cfg_dly1`=0 selects half-period delay; `cfg_nsamp`=0 with `cfg_dly1`=1 selects full-period delay.
- R2: In normal mode, a strobe accepted at clock edge e captures MISO as sampled at edge e. `rx_valid` and `rx_bit` become visible after edge e.
- R3: In half-period mode with half-period length H, the strobe of edge e leads to a capture of MISO at edge e+H. The result is visible after that edge.
- R4: In full-period mode, the capture happens at edge e+2H.
- R5: The reserved setting `cfg_nsamp`=1 with `cfg_dly1`=1 behaves exactly as normal capture.
- R6: Each accepted strobe produces exactly one `rx_valid` pulse, one module-clock cycle wide, in every mode. Strobe spacing is at least two cycles.
- R7: `rx_last` is asserted only together with `rx_valid`, on the capture that belongs to the strobe marked by `samp_last`. In delayed modes, `cap_pending` is high from the cycle after the strobe until the capture edge. This holds even after `xfer_active` has fallen.
- R8: Mode and half-period length are taken only while `xfer_active` is low and no capture is pending. Changes to them during a transfer do not alter that transfer's captures.
- R9: Strobes presented while `xfer_active` is low are ignored and produce no output.
- R10: After reset, `rx_valid`, `rx_last`, `rx_bit` and `cap_pending` are 0.
- R11: In full-period mode, a capture that expires in the same cycle as a new strobe arrives loses neither bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nsamp | input | 1 | Normal-capture select (control register bit 13) |
| cfg_dly1 | input | 1 | Full-period delay select (control register bit 11) |
| half_per | input | CNT_W | Module clocks per SCK half period (0 treated as 1) |
| xfer_active | input | 1 | Transfer in progress |
| samp_stb | input | 1 | Nominal sample-edge strobe, one cycle |
| samp_last | input | 1 | Marks the strobe of the final bit of a word |
| miso | input | 1 | Synchronized MISO |
| rx_valid | output | 1 | Captured bit valid, one-cycle pulse |
| rx_bit | output | 1 | Captured MISO value |
| rx_last | output | 1 | Captured bit is the final bit of the word |
| cap_pending | output | 1 | A delayed capture is still outstanding |

## Verification
The colliding pair is the expiry of a delayed capture and the acceptance of a fresh strobe. In full-period mode, strobes spaced exactly 2H apart make both land on the same edge, and the bench drives words with that spacing for every half-period length in its sweep. The bench predicts each capture edge arithmetically from the strobe edge plus the mode's delay, and predicts the MISO value at that edge from a closed-form pattern. It then demands one valid pulse per strobe with the right bit and last flag. A missed or doubled pulse at the collision edge shows up as a mismatch there.

// File: rtl/mcap_pkg.sv
package mcap_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_HALF = 2'd1,
    MODE_FULL = 2'd2
  } cap_mode_e;

  // R1 / R5: the reserved combination falls back to normal capture
  function automatic cap_mode_e decode_mode(input logic nsamp, input logic dly1);
    if (nsamp)     return MODE_NORM;
    else if (dly1) return MODE_FULL;
    else           return MODE_HALF;
  endfunction

endpackage

// File: rtl/mcap_cfg_latch.sv
module mcap_cfg_latch
  import mcap_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_nsamp,
  input  logic             cfg_dly1,
  input  logic [CNT_W-1:0] half_per,
  input  logic             xfer_active,
  input  logic             pending,
  output cap_mode_e        mode_q,
  output logic [CNT_W:0]   dly_q
);
  localparam int DW = CNT_W + 1;

  logic [CNT_W-1:0] hp_eff;
  cap_mode_e        mode_d;
  logic [DW-1:0]    dly_d;

  always_comb begin
    hp_eff = (half_per == '0) ? CNT_W'(1) : half_per;
    mode_d = decode_mode(cfg_nsamp, cfg_dly1);
    case (mode_d)
      MODE_HALF: dly_d = {1'b0, hp_eff};
      MODE_FULL: dly_d = {hp_eff, 1'b0};
      default:   dly_d = '0;
    endcase
  end

  // R8: configuration only moves while the bus is idle and drained
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORM;
      dly_q  <= '0;
    end else if (!xfer_active && !pending) begin
      mode_q <= mode_d;
      dly_q  <= dly_d;
    end
  end

endmodule

// File: rtl/mcap_delay_slot.sv
module mcap_delay_slot #(
  parameter int CNT_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [CNT_W:0] load_cnt,
  input  logic         load_last,
  output logic         busy,
  output logic         fire,
  output logic         last_q
);
  logic [CNT_W:0] cnt_q;

  assign fire = busy && (cnt_q == (CNT_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      cnt_q  <= load_cnt;
      last_q <= load_last;
    end else if (fire) begin
      busy   <= 1'b0;
      last_q <= 1'b0;
    end else if (busy) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/mcap_out_stage.sv
module mcap_out_stage #(
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             norm_fire,
  input  logic             norm_last,
  input  logic [NSLOT-1:0] slot_fire,
  input  logic [NSLOT-1:0] slot_last,
  input  logic             miso,
  output logic             rx_valid,
  output logic             rx_bit,
  output logic             rx_last
);
  logic any_fire;
  logic last_d;

  always_comb begin
    any_fire = norm_fire | (|slot_fire);
    last_d   = norm_fire ? norm_last : (|(slot_fire & slot_last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
      rx_last  <= 1'b0;
    end else begin
      rx_valid <= any_fire;
      rx_last  <= any_fire & last_d;
      if (any_fire) rx_bit <= miso;
    end
  end

endmodule

// File: rtl/miso_capture_align.sv
module miso_capture_align
  import mcap_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_nsamp,
  input  logic             cfg_dly1,
  input  logic [CNT_W-1:0] half_per,
  input  logic             xfer_active,
  input  logic             samp_stb,
  input  logic             samp_last,
  input  logic             miso,
  output logic             rx_valid,
  output logic             rx_bit,
  output logic             rx_last,
  output logic             cap_pending
);
  cap_mode_e        mode_q;
  logic [CNT_W:0]   dly_q;
  logic             accept;
  logic             norm_fire;
  logic             slot_req;
  logic [NSLOT-1:0] busy_vec;
  logic [NSLOT-1:0] fire_vec;
  logic [NSLOT-1:0] last_vec;
  logic [NSLOT-1:0] load_vec;
  logic             taken;

  assign cap_pending = |busy_vec;

  mcap_cfg_latch #(.CNT_W(CNT_W)) cfg_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_nsamp   (cfg_nsamp),
    .cfg_dly1    (cfg_dly1),
    .half_per    (half_per),
    .xfer_active (xfer_active),
    .pending     (cap_pending),
    .mode_q      (mode_q),
    .dly_q       (dly_q)
  );

  always_comb begin
    accept    = samp_stb & xfer_active;
    norm_fire = accept & (mode_q == MODE_NORM);
    slot_req  = accept & (mode_q != MODE_NORM);
    load_vec  = '0;
    taken     = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_req && !busy_vec[i] && !taken) begin
        load_vec[i] = 1'b1;
        taken       = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    mcap_delay_slot #(.CNT_W(CNT_W)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_vec[g]),
      .load_cnt  (dly_q),
      .load_last (samp_last),
      .busy      (busy_vec[g]),
      .fire      (fire_vec[g]),
      .last_q    (last_vec[g])
    );
  end

  mcap_out_stage #(.NSLOT(NSLOT)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .norm_fire (norm_fire),
    .norm_last (samp_last),
    .slot_fire (fire_vec),
    .slot_last (last_vec),
    .miso      (miso),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .rx_last   (rx_last)
  );

endmodule

// File: rtl/mcap_chk.sv
module mcap_chk
  import mcap_pkg::*;
#(
  parameter int NSLOT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_active,
  input logic             samp_stb,
  input logic             miso,
  input logic             rx_valid,
  input logic             rx_bit,
  input logic             rx_last,
  input cap_mode_e        mode_q,
  input logic [NSLOT-1:0] busy_vec,
  input logic [NSLOT-1:0] fire_vec
);
  // R2
  norm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_stb && xfer_active && mode_q == MODE_NORM) |=> (rx_valid && rx_bit == $past(miso)));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  single_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));

  // R7
  last_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last |-> rx_valid);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && $past(xfer_active)) |-> $stable(mode_q));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && busy_vec == '0) |=> !rx_valid);

  // R11
  no_slot_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_stb && xfer_active && mode_q != MODE_NORM) |-> (busy_vec != {NSLOT{1'b1}}));

endmodule

bind miso_capture_align mcap_chk #(.NSLOT(NSLOT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_active (xfer_active),
  .samp_stb    (samp_stb),
  .miso        (miso),
  .rx_valid    (rx_valid),
  .rx_bit      (rx_bit),
  .rx_last     (rx_last),
  .mode_q      (mode_q),
  .busy_vec    (busy_vec),
  .fire_vec    (fire_vec)
);

// File: tb/miso_capture_align_tb_top.sv
module miso_capture_align_tb_top;
  localparam int CNT_W = 4;
  localparam int N     = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_nsamp = 1'b1, cfg_dly1 = 1'b0;
  logic [CNT_W-1:0] half_per = CNT_W'(1);
  logic xfer_active = 1'b0, samp_stb = 1'b0, samp_last = 1'b0, miso = 1'b0;
  logic rx_valid, rx_bit, rx_last, cap_pending;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  bit exp_v [N];
  bit exp_b [N];
  bit exp_l [N];
  int exp_p [N];
  string exp_tag [N];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  miso_capture_align #(.CNT_W(CNT_W), .NSLOT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_nsamp(cfg_nsamp), .cfg_dly1(cfg_dly1),
    .half_per(half_per), .xfer_active(xfer_active), .samp_stb(samp_stb),
    .samp_last(samp_last), .miso(miso), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_last(rx_last), .cap_pending(cap_pending)
  );

  function automatic bit miso_of(input int c);
    return bit'((c ^ (c >> 1) ^ (c >> 3) ^ (c >> 6)) & 1);
  endfunction

  task automatic report(input string req, input int act, input int exp_val, input string what);
    failures++;
    $display("FAIL %s %s actual=%0d expected=%0d cyc=%0d", req, what, act, exp_val, cyc);
  endtask

  // Monitor: outputs change only on posedge, sampled here at negedge
  always @(negedge clk) begin
    if (mon_en) begin
      automatic int idx = cyc % N;
      if (exp_v[idx] || rx_valid) begin
        checks++;
        if (rx_valid !== exp_v[idx])
          report(exp_v[idx] ? exp_tag[idx] : "R9", int'(rx_valid), int'(exp_v[idx]), "rx_valid (R6)");
        else begin
          checks++;
          if (rx_bit !== exp_b[idx]) report(exp_tag[idx], int'(rx_bit), int'(exp_b[idx]), "rx_bit");
          checks++;
          if (rx_last !== exp_l[idx]) report("R7", int'(rx_last), int'(exp_l[idx]), "rx_last");
        end
      end else if (rx_last !== 1'b0) begin
        checks++;
        report("R7", int'(rx_last), 0, "rx_last without valid");
      end
      checks++;
      if (cap_pending !== (exp_p[idx] != 0))
        report("R7", int'(cap_pending), int'(exp_p[idx] != 0), "cap_pending");
      exp_v[idx] = 1'b0;
      exp_l[idx] = 1'b0;
      exp_p[idx] = 0;
    end
  end

  task automatic step(input bit act, input bit stb, input bit lst, input int d, input string tag);
    @(negedge clk);
    begin
      automatic int c = cyc;
      xfer_active = act;
      samp_stb    = stb;
      samp_last   = lst;
      miso        = miso_of(c);
      if (stb && act) begin
        automatic int k = (c + d + 1) % N;
        exp_v[k]   = 1'b1;
        exp_b[k]   = miso_of(c + d);
        exp_l[k]   = lst;
        exp_tag[k] = tag;
        for (int j = c + 1; j <= c + d; j++) exp_p[j % N]++;
      end
    end
  endtask

  // One word of nbits strobes spaced 2H apart; optional mid-word config flip
  task automatic run_word(input bit ns, input bit d1, input int h, input int nbits,
                          input bit flip, input string tag);
    automatic int d = ns ? 0 : (d1 ? 2 * h : h);
    @(negedge clk);
    cfg_nsamp = ns;
    cfg_dly1  = d1;
    half_per  = CNT_W'(h);
    repeat (3) step(1'b0, 1'b0, 1'b0, 0, tag);
    for (int b = 0; b < nbits; b++) begin
      if (flip && b == 3) begin
        cfg_nsamp = ~cfg_nsamp;
        cfg_dly1  = ~cfg_dly1;
        half_per  = CNT_W'(h + 2);
      end
      step(1'b1, 1'b1, b == nbits - 1, d, tag);
      repeat (2 * h - 1) step(1'b1, 1'b0, 1'b0, d, tag);
    end
    repeat (2 * h + 3) step(1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10: reset values
    checks++; if (rx_valid !== 1'b0) report("R10", int'(rx_valid), 0, "rx_valid");
    checks++; if (rx_bit !== 1'b0) report("R10", int'(rx_bit), 0, "rx_bit");
    checks++; if (rx_last !== 1'b0) report("R10", int'(rx_last), 0, "rx_last");
    checks++; if (cap_pending !== 1'b0) report("R10", int'(cap_pending), 0, "cap_pending");
    rst_n = 1'b1;
    mon_en = 1'b1;

    // Sweep all four control codes over several half-period lengths
    for (int h = 1; h <= 3; h++) begin
      run_word(1'b1, 1'b0, h, 8, 1'b0, "R2");  // R1 normal
      run_word(1'b0, 1'b0, h, 8, 1'b0, "R3");  // R1 half-period
      run_word(1'b0, 1'b1, h, 8, 1'b0, "R4");  // R1 full-period, R11 collisions
      run_word(1'b1, 1'b1, h, 8, 1'b0, "R5");  // reserved code
    end
    run_word(1'b0, 1'b1, 5, 6, 1'b0, "R11");

    // R8: config flipped mid-word keeps the word's mode; next word uses new one
    run_word(1'b0, 1'b1, 2, 8, 1'b1, "R8");
    run_word(1'b1, 1'b0, 4, 8, 1'b0, "R8");
    run_word(1'b0, 1'b0, 2, 8, 1'b1, "R8");
    run_word(1'b1, 1'b1, 4, 8, 1'b0, "R8");

    // R9: strobes while idle are ignored, in normal and delayed configs
    cfg_nsamp = 1'b1; cfg_dly1 = 1'b0;
    repeat (3) step(1'b0, 1'b0, 1'b0, 0, "R9");
    repeat (4) begin
      step(1'b0, 1'b1, 1'b1, 0, "R9");
      step(1'b0, 1'b0, 1'b0, 0, "R9");
    end
    cfg_nsamp = 1'b0; cfg_dly1 = 1'b1;
    repeat (3) step(1'b0, 1'b0, 1'b0, 0, "R9");
    repeat (4) begin
      step(1'b0, 1'b1, 1'b0, 0, "R9");
      step(1'b0, 1'b0, 1'b0, 0, "R9");
    end
    repeat (8) step(1'b0, 1'b0, 1'b0, 0, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule